// File: doc/BRIEF.md
# Video RAM Host Write Port

This block sits between an 8-bit host bus and the write side of a 16-bit, word-addressed video memory. The host sees three byte addresses. Address 0 chooses which internal register the next data bytes go to. Address 2 carries the low byte of that register. Address 3 carries its high byte.

Two internal registers matter: the word write address (index 0) and the data-write register (index 2). A low data byte only fills a holding latch. The high data byte then sends the full word to memory and steps the address forward by one word. The held low byte is never cleared by a commit, so a fill of constant-low-byte words needs one host write per word.

Memory writes leave the block only in host access slots, which recur on a rotation chosen by a mode input. While a word waits for its slot, the host is stalled through a ready output.

Top module: `vram_wport`

## Requirements
- R1: A write to host address 0 loads the register index from the low bits of the data byte. A write to host address 1 changes nothing.
- R2: With index 0 selected, a low byte at host address 2 and then a high byte at host address 3 set the 16-bit word write address to {high, low}. The address changes only when the high byte is written.
- R3: With index 2 selected, a low byte at host address 2 only updates the held low byte and never causes a memory write.
- R4: With index 2 selected, a high byte at host address 3 commits the word {high byte, held low byte} to the current write address.
- R5: The held low byte survives commits, so each later high-byte-only write stores a word with the same low byte.
- R6: Every commit advances the write address by one word, and the address wraps from 16'hFFFF to 0.
- R7: mem_we pulses only in host access slots. A slot is a clock edge at which the number of edges since reset release is a multiple of 2^slot_mode.
- R8: host_ready is low from the edge after a commit until the edge at which that commit reaches memory. Host writes offered while host_ready is low are not taken, and no commit is lost.
- R9: Low or high bytes written while an index other than 0 or 2 is selected change neither the address nor the held low byte, and cause no memory write.
- R10: After reset, host_ready is high, mem_we is low, the write address is 0 and the held low byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe, taken when host_ready is high |
| host_sel | input | 2 | Host byte address (0 index, 2 low byte, 3 high byte) |
| host_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | Low while a committed word waits for its slot |
| slot_mode | input | 2 | Slot rotation: one slot every 2^slot_mode cycles |
| mem_we | output | 1 | Registered video memory write enable |
| mem_addr | output | 16 | Registered word address of the memory write |
| mem_wdata | output | 16 | Registered word written to memory |

## Verification
The bench writes the high byte repeatedly after a single low byte. A design that cleared or dropped the held low byte would store 00 in the low half of later words. It drives the address to 16'hFFFF and commits twice, so a missing wrap or an off-by-one increment shows up as a word at the wrong location. It runs the slowest slot rotation and checks the phase of every memory write, which catches a design that ignores the mode or lets writes through outside slots. It also writes through index 1 and host address 1, so a design that decodes these loosely would move the address or corrupt the held byte.

// File: rtl/vram_wport_pkg.sv
package vram_wport_pkg;
  localparam logic [1:0] HA_INDEX  = 2'd0;
  localparam logic [1:0] HA_LOW    = 2'd2;
  localparam logic [1:0] HA_HIGH   = 2'd3;
  localparam int         IDX_W     = 5;
  localparam logic [IDX_W-1:0] RI_WADDR = 5'd0;
  localparam logic [IDX_W-1:0] RI_WDATA = 5'd2;
endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] slot_mode,
  output logic              slot_hit
);
  localparam int CNT_W = (1 << MODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  // period = 2^slot_mode, so the phase mask is period-1
  assign mask     = ~({CNT_W{1'b1}} << slot_mode);
  assign slot_hit = ((cnt & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vram_host_regs.sv
module vram_host_regs
  import vram_wport_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [1:0]    sel,
  input  logic [7:0]    wdata,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [15:0]   commit_data
);
  logic [IDX_W-1:0] idx;
  logic [7:0]       addr_stage;
  logic [7:0]       data_low;
  logic [AW-1:0]    waddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      addr_stage <= '0;
      data_low   <= '0;
      waddr      <= '0;
    end else if (accept) begin
      case (sel)
        HA_INDEX: idx <= wdata[IDX_W-1:0];
        HA_LOW: begin
          if (idx == RI_WADDR)      addr_stage <= wdata;
          else if (idx == RI_WDATA) data_low   <= wdata;
        end
        HA_HIGH: begin
          if (idx == RI_WADDR)      waddr <= AW'({wdata, addr_stage});
          else if (idx == RI_WDATA) waddr <= waddr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign commit      = accept && (sel == HA_HIGH) && (idx == RI_WDATA);
  assign commit_addr = waddr;
  assign commit_data = {wdata, data_low};
endmodule

// File: rtl/vram_wport.sv
module vram_wport #(
  parameter int AW     = 16,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [7:0]        host_wdata,
  output logic              host_ready,
  input  logic [MODE_W-1:0] slot_mode,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata
);
  logic          slot_hit;
  logic          accept;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [15:0]   commit_data;
  logic          pend_v;
  logic [AW-1:0] pend_addr;
  logic [15:0]   pend_data;

  assign host_ready = ~pend_v;
  assign accept     = host_wr & host_ready;

  vram_slot_timer #(.MODE_W(MODE_W)) u_slot (
    .clk(clk), .rst(rst), .slot_mode(slot_mode), .slot_hit(slot_hit)
  );

  vram_host_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .sel(host_sel), .wdata(host_wdata),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  // one pending word; a new commit is only taken while this is empty
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (pend_v && slot_hit) begin
        mem_we    <= 1'b1;
        mem_addr  <= pend_addr;
        mem_wdata <= pend_data;
        pend_v    <= 1'b0;
      end
      if (commit) begin
        pend_v    <= 1'b1;
        pend_addr <= commit_addr;
        pend_data <= commit_data;
      end
    end
  end
endmodule

// File: rtl/vram_wport_chk.sv
module vram_wport_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic [1:0] host_sel,
  input logic       host_ready,
  input logic       mem_we,
  input logic       slot_hit,
  input logic       commit
);
  a_r7_slot_only: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(slot_hit));

  a_r8_stall_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> !host_ready);

  a_r8_release_on_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> host_ready);

  a_r3_no_write_without_high: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_ready && host_sel != 2'd3) |=> !mem_we);

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && host_ready));
endmodule

bind vram_wport vram_wport_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
  .host_ready(host_ready), .mem_we(mem_we), .slot_hit(slot_hit), .commit(commit)
);

// File: tb/vram_wport_test.sv
module vram_wport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [1:0]  slot_mode = 2'd0;
  logic        host_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int fails = 0;
  int we_count = 0;
  int bc = 0;
  int phase_err = 0;
  bit done = 0;
  logic [15:0] model [int];

  always #2 clk = ~clk;

  vram_wport uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ready(host_ready), .slot_mode(slot_mode),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (rst) bc <= 0;
    else     bc <= bc + 1;
  end

  // memory model and R7 slot-phase monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      model[int'(mem_addr)] = mem_wdata;
      we_count++;
      if (((bc - 1) % (1 << slot_mode)) != 0) phase_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic mem_chk(input int a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    v = model.exists(a) ? model[a] : 16'hxxxx;
    chk(model.exists(a) && v === exp, req, int'(v), int'(exp));
  endtask

  // {host_sel, data}
  localparam logic [9:0] OPS [12] = '{
    {2'd0, 8'h00}, {2'd2, 8'h10}, {2'd3, 8'h00},
    {2'd0, 8'h02}, {2'd2, 8'hAB}, {2'd3, 8'h12}, {2'd3, 8'h34},
    {2'd2, 8'h01}, {2'd3, 8'h56}, {2'd3, 8'h57},
    {2'd1, 8'h00}, {2'd3, 8'h58}
  };
  // {address, word}
  localparam logic [31:0] EXP [6] = '{
    {16'h0010, 16'h12AB}, {16'h0011, 16'h34AB}, {16'h0012, 16'h5601},
    {16'h0013, 16'h5701}, {16'h0014, 16'h5801}, {16'h0015, 16'h0000}
  };

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(host_ready === 1'b1, "R10 ready", host_ready, 1);
    chk(mem_we === 1'b0, "R10 we", mem_we, 0);

    // R2 R4 R5 R6 R1 vector walk
    for (int i = 0; i < 12; i++) hw(OPS[i][9:8], OPS[i][7:0]);
    drain();
    for (int i = 0; i < 5; i++)
      mem_chk(int'(EXP[i][31:16]), EXP[i][15:0], "R4_R5_R6_R1 table");
    chk(we_count == 5, "R1 host addr 1 ignored", we_count, 5);

    // R3 low byte alone writes nothing
    wc = we_count;
    hw(2'd2, 8'hC3);
    repeat (10) @(negedge clk);
    chk(we_count == wc, "R3 low byte only", we_count, wc);

    // R9 unused index 1: writes ignored, address and latch kept
    hw(2'd0, 8'h01); hw(2'd2, 8'h77); hw(2'd3, 8'h88);
    repeat (6) @(negedge clk);
    chk(we_count == wc, "R9 no write", we_count, wc);
    hw(2'd0, 8'h02); hw(2'd3, 8'h99);
    drain();
    mem_chk(16'h0015, 16'h99C3, "R9 state kept");

    // R6 wrap at top of address space
    hw(2'd0, 8'h00); hw(2'd2, 8'hFF); hw(2'd3, 8'hFF);
    hw(2'd0, 8'h02); hw(2'd2, 8'h5A); hw(2'd3, 8'hA1); hw(2'd3, 8'hA2);
    drain();
    mem_chk(16'hFFFF, 16'hA15A, "R6 top");
    mem_chk(16'h0000, 16'hA25A, "R6 wrap");

    // R8 stall and R7 slow rotation
    slot_mode = 2'd3;
    repeat (3) @(negedge clk);
    wc = we_count;
    hw(2'd3, 8'hB1);
    chk(host_ready === 1'b0 || we_count == wc + 1, "R8 stall", host_ready, 0);
    hw(2'd3, 8'hB2); hw(2'd3, 8'hB3); hw(2'd3, 8'hB4);
    drain();
    chk(we_count == wc + 4, "R8 no loss", we_count, wc + 4);
    mem_chk(16'h0001, 16'hB15A, "R8 first");
    mem_chk(16'h0004, 16'hB45A, "R8 last");
    slot_mode = 2'd1;
    hw(2'd3, 8'hC1); hw(2'd3, 8'hC2);
    drain();
    mem_chk(16'h0006, 16'hC25A, "R7 mode 1");
    chk(phase_err == 0, "R7 slot phase", phase_err, 0);
    done = 1;
  end

  initial begin
    int t = 0;
    while (!done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", t);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule